// File: doc/BRIEF.md
# Time-Slotted Shared Word RAM with Byte-Wide Processor Bridge

This block holds a 128-entry, 32-bit data RAM that four agents share: a filter stage, a real-time monitor port, a compute engine and a byte-wide microprocessor. A free-running sequencer splits time into a four-cycle frame. Each agent may touch the RAM only in its own cycle of that frame. Because of this, two agents never drive the RAM port in the same cycle, and there is no request and grant logic. The sequencer visits the states `SL_FLT` → `SL_MON` → `SL_CPU` → `SL_CE` and then returns to `SL_FLT`, one step per clock. The filter, monitor and processor slots are reserved slots. The compute engine uses the remaining slot.

The filter, the monitor and the compute engine each have a full-word port. Each port has an enable, a write flag, a word address and write data, and its own registered read result. The processor side is 8 bits wide. A holding-register bridge latches one byte request and lowers `cpu_ready`, then finishes the transfer in the next processor slot. On a write, the bridge reads the addressed word, replaces the selected byte and writes the whole word back in that same slot. On a read, it loads the word into its holding register and presents the selected byte.

The bridge has two states. `BR_IDLE` has `cpu_ready` high and accepts a request. The transition `BR_IDLE`→`BR_WAIT` takes place when `cpu_req` is high. The transition `BR_WAIT`→`BR_IDLE` takes place at the end of a `SL_CPU` cycle, after the transfer. By convention, the filter stage places its converted inputs in words 0 to 7, in this order: phase A current, phase A voltage, phase B current, phase B voltage, two spare words, temperature, battery voltage.

Top module: `slot_ram_top`

## Requirements
- R1: After reset, `slot` is 0, `cpu_ready` is 1, every read output is 0, and every RAM word reads as 0.
- R2: `slot` counts 0 (filter), 1 (monitor), 2 (processor), 3 (compute engine), and repeats. It advances by exactly one each clock.
- R3: When the filter, monitor or compute-engine port has enable and write high during its own slot, the full 32-bit word is stored at its word address.
- R4: When a word port has enable high and write low during its own slot, its read output loads the addressed word at the end of that cycle. At all other times the read output keeps its value.
- R5: An enable presented by a word port outside its own slot has no effect: no RAM word changes and its read output does not change.
- R6: The processor byte address is 9 bits. Bits [8:2] pick the word and bits [1:0] pick the byte, little-endian: byte 0 is bits [7:0] and byte 3 is bits [31:24].
- R7: A processor byte write changes only the selected byte of the word. The other three bytes keep their stored values.
- R8: After a processor read, once `cpu_ready` is high again, `cpu_rdata` holds the selected byte of the addressed word.
- R9: `cpu_ready` goes low in the cycle after a request is accepted. It goes high again in the cycle after the next processor slot. A request made while `cpu_ready` is low is ignored.
- R10: A request accepted in a cycle with slot value s keeps `cpu_ready` low for ((1 − s) mod 4) + 1 cycles. That gives 2, 1, 4 and 3 cycles for s = 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot | output | 2 | Current frame slot (0 filter, 1 monitor, 2 processor, 3 compute engine) |
| flt_en | input | 1 | Filter access enable |
| flt_we | input | 1 | Filter write flag |
| flt_addr | input | 7 | Filter word address |
| flt_wdata | input | 32 | Filter write word |
| flt_rdata | output | 32 | Filter read result |
| mon_en | input | 1 | Monitor access enable |
| mon_we | input | 1 | Monitor write flag |
| mon_addr | input | 7 | Monitor word address |
| mon_wdata | input | 32 | Monitor write word |
| mon_rdata | output | 32 | Monitor read result |
| ce_en | input | 1 | Compute-engine access enable |
| ce_we | input | 1 | Compute-engine write flag |
| ce_addr | input | 7 | Compute-engine word address |
| ce_wdata | input | 32 | Compute-engine write word |
| ce_rdata | output | 32 | Compute-engine read result |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write flag |
| cpu_addr | input | 9 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte |
| cpu_ready | output | 1 | Processor ready; low during wait states |

## Verification
A vector table runs writes and reads through every agent, and the bench compares each word against its own model. Writes on one port that are read back on another port show whether the agents share one storage array. Processor byte writes to different lanes of a word, read back through a word port, show whether the byte lanes stay separate and whether the lane order is right. Requests issued in each of the four slots show whether the wait-state count follows the slot phase. Enables held through other agents' slots, and a second request made while busy, show whether out-of-turn stimulus is truly ignored.

// File: rtl/slot_ram_pkg.sv
package slot_ram_pkg;

    typedef enum logic [1:0] {
        SL_FLT = 2'd0,
        SL_MON = 2'd1,
        SL_CPU = 2'd2,
        SL_CE  = 2'd3
    } slot_e;

    typedef enum logic {
        BR_IDLE = 1'b0,
        BR_WAIT = 1'b1
    } br_state_e;

    // slot owned by each full-word agent: filter, monitor, compute engine
    localparam int unsigned N_WORD_AGENTS = 3;
    localparam slot_e AG_SLOT [N_WORD_AGENTS] = '{SL_FLT, SL_MON, SL_CE};

    // word indices used by the filter for converted inputs
    localparam int unsigned WI_CUR_A  = 0;
    localparam int unsigned WI_VOLT_A = 1;
    localparam int unsigned WI_CUR_B  = 2;
    localparam int unsigned WI_VOLT_B = 3;
    localparam int unsigned WI_TEMP   = 6;
    localparam int unsigned WI_BATT   = 7;

endpackage

// File: rtl/slot_seq.sv
module slot_seq
    import slot_ram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);

    slot_e slot_nx;

    always_comb begin
        unique case (slot)
            SL_FLT:  slot_nx = SL_MON;
            SL_MON:  slot_nx = SL_CPU;
            SL_CPU:  slot_nx = SL_CE;
            SL_CE:   slot_nx = SL_FLT;
            default: slot_nx = SL_FLT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SL_FLT;
        else        slot <= slot_nx;
    end

endmodule

// File: rtl/slot_ram_store.sv
module slot_ram_store #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/word_agent_port.sv
module word_agent_port
    import slot_ram_pkg::*;
#(
    parameter slot_e MY = SL_FLT,
    parameter int    DW = 32,
    parameter int    AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         slot,
    input  logic          en,
    input  logic          we,
    input  logic [DW-1:0] mem_rd,
    output logic          wr,
    output logic [DW-1:0] rdata
);

    logic mine;

    always_comb begin
        mine = (slot == MY);
        wr   = mine && en && we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata <= '0;
        else if (mine && en && !we) rdata <= mem_rd;
    end

endmodule

// File: rtl/cpu_byte_bridge.sv
module cpu_byte_bridge
    import slot_ram_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 7,
    localparam int NB    = DW / 8,
    localparam int BW    = $clog2(NB),
    localparam int BAW   = AW + BW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  slot_e          slot,
    input  logic           req,
    input  logic           we,
    input  logic [BAW-1:0] baddr,
    input  logic [7:0]     wbyte,
    input  logic [DW-1:0]  mem_rd,
    output logic           ready,
    output logic [7:0]     rbyte,
    output logic [AW-1:0]  word_addr,
    output logic           commit_we,
    output logic [DW-1:0]  commit_word
);

    br_state_e      st, st_nx;
    logic [BAW-1:0] addr_q;
    logic           we_q;
    logic [7:0]     byte_q;
    logic [DW-1:0]  hold_q;
    logic [BW-1:0]  lane;
    logic           xfer;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            BR_IDLE: if (req)            st_nx = BR_WAIT;
            BR_WAIT: if (slot == SL_CPU) st_nx = BR_IDLE;
            default:                     st_nx = BR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BR_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        lane        = addr_q[BW-1:0];
        word_addr   = addr_q[BAW-1:BW];
        ready       = (st == BR_IDLE);
        xfer        = (st == BR_WAIT) && (slot == SL_CPU);
        commit_we   = xfer && we_q;
        commit_word = mem_rd;
        commit_word[lane*8 +: 8] = byte_q;
        rbyte       = hold_q[lane*8 +: 8];
    end

    // holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
            byte_q <= '0;
            hold_q <= '0;
        end else begin
            if (st == BR_IDLE && req) begin
                addr_q <= baddr;
                we_q   <= we;
                byte_q <= wbyte;
            end
            if (xfer) hold_q <= we_q ? commit_word : mem_rd;
        end
    end

endmodule

// File: rtl/slot_ram_top.sv
module slot_ram_top
    import slot_ram_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int DW     = 32,
    localparam int AW    = $clog2(WORDS),
    localparam int BW    = $clog2(DW / 8),
    localparam int BAW   = AW + BW
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [1:0]     slot,
    input  logic           flt_en,
    input  logic           flt_we,
    input  logic [AW-1:0]  flt_addr,
    input  logic [DW-1:0]  flt_wdata,
    output logic [DW-1:0]  flt_rdata,
    input  logic           mon_en,
    input  logic           mon_we,
    input  logic [AW-1:0]  mon_addr,
    input  logic [DW-1:0]  mon_wdata,
    output logic [DW-1:0]  mon_rdata,
    input  logic           ce_en,
    input  logic           ce_we,
    input  logic [AW-1:0]  ce_addr,
    input  logic [DW-1:0]  ce_wdata,
    output logic [DW-1:0]  ce_rdata,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [BAW-1:0] cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    output logic           cpu_ready
);

    slot_e         slot_q;
    logic [DW-1:0] mem_rd;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;

    logic [N_WORD_AGENTS-1:0] ag_en, ag_we, ag_wr;
    logic [AW-1:0]            ag_addr  [N_WORD_AGENTS];
    logic [DW-1:0]            ag_wdata [N_WORD_AGENTS];
    logic [DW-1:0]            ag_rdata [N_WORD_AGENTS];

    logic [AW-1:0] br_addr;
    logic          br_we;
    logic [DW-1:0] br_word;

    assign slot = slot_q;

    assign ag_en       = {ce_en, mon_en, flt_en};
    assign ag_we       = {ce_we, mon_we, flt_we};
    assign ag_addr[0]  = flt_addr;
    assign ag_addr[1]  = mon_addr;
    assign ag_addr[2]  = ce_addr;
    assign ag_wdata[0] = flt_wdata;
    assign ag_wdata[1] = mon_wdata;
    assign ag_wdata[2] = ce_wdata;
    assign flt_rdata   = ag_rdata[0];
    assign mon_rdata   = ag_rdata[1];
    assign ce_rdata    = ag_rdata[2];

    slot_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot_q)
    );

    for (genvar g = 0; g < N_WORD_AGENTS; g++) begin : g_ag
        word_agent_port #(
            .MY (AG_SLOT[g]),
            .DW (DW),
            .AW (AW)
        ) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .slot   (slot_q),
            .en     (ag_en[g]),
            .we     (ag_we[g]),
            .mem_rd (mem_rd),
            .wr     (ag_wr[g]),
            .rdata  (ag_rdata[g])
        );
    end

    cpu_byte_bridge #(
        .DW (DW),
        .AW (AW)
    ) u_bridge (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (slot_q),
        .req         (cpu_req),
        .we          (cpu_we),
        .baddr       (cpu_addr),
        .wbyte       (cpu_wdata),
        .mem_rd      (mem_rd),
        .ready       (cpu_ready),
        .rbyte       (cpu_rdata),
        .word_addr   (br_addr),
        .commit_we   (br_we),
        .commit_word (br_word)
    );

    // slot-owned RAM port selection
    always_comb begin
        unique case (slot_q)
            SL_FLT: begin
                ram_addr = ag_addr[0]; ram_we = ag_wr[0]; ram_wdata = ag_wdata[0];
            end
            SL_MON: begin
                ram_addr = ag_addr[1]; ram_we = ag_wr[1]; ram_wdata = ag_wdata[1];
            end
            SL_CPU: begin
                ram_addr = br_addr;    ram_we = br_we;    ram_wdata = br_word;
            end
            SL_CE: begin
                ram_addr = ag_addr[2]; ram_we = ag_wr[2]; ram_wdata = ag_wdata[2];
            end
            default: begin
                ram_addr = '0;         ram_we = 1'b0;     ram_wdata = '0;
            end
        endcase
    end

    slot_ram_store #(
        .WORDS (WORDS),
        .DW    (DW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (mem_rd)
    );

endmodule

// File: rtl/slot_ram_chk.sv
module slot_ram_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    slot,
    input logic          cpu_req,
    input logic          cpu_ready,
    input logic [DW-1:0] flt_rdata,
    input logic [DW-1:0] mon_rdata,
    input logic [DW-1:0] ce_rdata
);

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot == 2'($past(slot) + 2'd1));

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_req |=> !cpu_ready);

    // R9
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready && slot == 2'd2 |=> cpu_ready);

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready && slot != 2'd2 |=> !cpu_ready);

    // R5
    flt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot != 2'd0 |=> $stable(flt_rdata));

    // R5
    mon_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot != 2'd1 |=> $stable(mon_rdata));

    // R5
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot != 2'd3 |=> $stable(ce_rdata));

endmodule

bind slot_ram_top slot_ram_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .flt_rdata (flt_rdata),
    .mon_rdata (mon_rdata),
    .ce_rdata  (ce_rdata)
);

// File: tb/slot_ram_top_test.sv
module slot_ram_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  slot;
    logic        flt_en = 0, flt_we = 0, mon_en = 0, mon_we = 0, ce_en = 0, ce_we = 0;
    logic [6:0]  flt_addr = 0, mon_addr = 0, ce_addr = 0;
    logic [31:0] flt_wdata = 0, mon_wdata = 0, ce_wdata = 0;
    logic [31:0] flt_rdata, mon_rdata, ce_rdata;
    logic        cpu_req = 0, cpu_we = 0;
    logic [8:0]  cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [128];

    always #5 clk = ~clk;

    slot_ram_top uut (.*);

    // ops: 0 flt wr, 1 mon wr, 2 ce wr, 3 cpu byte wr, 4 cpu byte rd,
    //      5 flt rd, 6 mon rd, 7 ce rd  ; fields {op, addr, data}
    localparam logic [43:0] VEC [14] = '{
        {3'd0, 9'h000, 32'h1122_3344},
        {3'd0, 9'h007, 32'h0BAD_F00D},
        {3'd1, 9'h040, 32'hA5A5_5A5A},
        {3'd2, 9'h07F, 32'hFFFF_FFFF},
        {3'd7, 9'h000, 32'h0},
        {3'd3, 9'h002, 32'h0000_00EE},
        {3'd4, 9'h003, 32'h0},
        {3'd4, 9'h002, 32'h0},
        {3'd3, 9'h1FF, 32'h0000_0000},
        {3'd7, 9'h07F, 32'h0},
        {3'd6, 9'h040, 32'h0},
        {3'd5, 9'h007, 32'h0},
        {3'd4, 9'h100, 32'h0},
        {3'd3, 9'h101, 32'h0000_0077}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ag_slot(int a);
        return (a == 0) ? 2'd0 : (a == 1) ? 2'd1 : 2'd3;
    endfunction

    task automatic wait_slot(logic [1:0] s);
        do @(negedge clk); while (slot != s);
    endtask

    task automatic drive_ag(int a, logic en, logic we, logic [6:0] ad, logic [31:0] d);
        case (a)
            0:       begin flt_en = en; flt_we = we; flt_addr = ad; flt_wdata = d; end
            1:       begin mon_en = en; mon_we = we; mon_addr = ad; mon_wdata = d; end
            default: begin ce_en  = en; ce_we  = we; ce_addr  = ad; ce_wdata  = d; end
        endcase
    endtask

    function automatic logic [31:0] get_rd(int a);
        return (a == 0) ? flt_rdata : (a == 1) ? mon_rdata : ce_rdata;
    endfunction

    task automatic word_wr(int a, logic [6:0] ad, logic [31:0] d);
        wait_slot(ag_slot(a));
        drive_ag(a, 1'b1, 1'b1, ad, d);
        @(negedge clk);
        drive_ag(a, 1'b0, 1'b0, 7'd0, 32'd0);
        model[ad] = d;
    endtask

    task automatic word_rd(int a, logic [6:0] ad, string tag);
        wait_slot(ag_slot(a));
        drive_ag(a, 1'b1, 1'b0, ad, 32'd0);
        @(negedge clk);
        drive_ag(a, 1'b0, 1'b0, 7'd0, 32'd0);
        check(tag, get_rd(a), model[ad]);
    endtask

    // byte access; checks wait count (R10) and read byte (R8)
    task automatic cpu_op(logic we, logic [8:0] ba, logic [7:0] d);
        int s, n, e;
        do @(negedge clk); while (!cpu_ready);
        s = int'(slot);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ba; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 0;
        while (!cpu_ready) begin
            n++;
            @(negedge clk);
        end
        e = (((1 - s) % 4 + 4) % 4) + 1;
        check("R10", n, e);
        if (we) model[ba[8:2]][ba[1:0]*8 +: 8] = d;
        else    check("R8", {24'd0, cpu_rdata}, {24'd0, model[ba[8:2]][ba[1:0]*8 +: 8]});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs right after reset
        check("R1", {30'd0, slot}, 32'd0);
        check("R1", {31'd0, cpu_ready}, 32'd1);
        check("R1", flt_rdata | mon_rdata | ce_rdata, 32'd0);
        check("R1", {24'd0, cpu_rdata}, 32'd0);

        // R2: slot sequence
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            check("R2", {30'd0, slot}, i % 4);
        end

        // R1: stored words are zero
        word_rd(2, 7'h20, "R1");
        word_rd(0, 7'h7F, "R1");

        // vector walk (R3 writes, R4 reads, R6 byte lanes)
        for (int i = 0; i < 14; i++) begin
            logic [2:0]  op;
            logic [8:0]  ad;
            logic [31:0] d;
            op = VEC[i][43:41]; ad = VEC[i][40:32]; d = VEC[i][31:0];
            case (op)
                3'd0: word_wr(0, ad[6:0], d);
                3'd1: word_wr(1, ad[6:0], d);
                3'd2: word_wr(2, ad[6:0], d);
                3'd3: cpu_op(1'b1, ad, d[7:0]);
                3'd4: begin
                    cpu_op(1'b0, ad, 8'd0);
                    // R6 lane check against the model word
                    check("R6", {24'd0, cpu_rdata}, {24'd0, model[ad[8:2]][ad[1:0]*8 +: 8]});
                end
                3'd5: word_rd(0, ad[6:0], "R3");
                3'd6: word_rd(1, ad[6:0], "R3");
                default: word_rd(2, ad[6:0], "R4");
            endcase
        end

        // R7: byte writes kept the other lanes
        word_rd(2, 7'h00, "R7");
        word_rd(0, 7'h7F, "R7");
        word_rd(1, 7'h40, "R7");
        check("R7", model[7'h40], 32'hA5A5_775A);
        check("R7", model[7'h00], 32'h11EE_3344);

        // R10: a request from each slot phase
        for (int s = 0; s < 4; s++) begin
            wait_slot(2'(s + 3));
            cpu_op(1'b0, 9'h01C, 8'd0);
        end

        // R9: second request while busy is ignored
        wait_slot(2'd1);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 9'h00C; cpu_wdata = 8'h12;
        @(negedge clk);
        check("R9", {31'd0, cpu_ready}, 32'd0);
        cpu_addr = 9'h010; cpu_wdata = 8'h34;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready) @(negedge clk);
        model[3][7:0] = 8'h12;
        word_rd(2, 7'd3, "R9");
        word_rd(2, 7'd4, "R9");

        // R5: filter write held through other slots
        wait_slot(2'd1);
        drive_ag(0, 1'b1, 1'b1, 7'd5, 32'hDEAD_BEEF);
        repeat (3) @(negedge clk);
        drive_ag(0, 1'b0, 1'b0, 7'd0, 32'd0);
        word_rd(2, 7'd5, "R5");
        // R5: compute-engine write outside its slot
        wait_slot(2'd0);
        drive_ag(2, 1'b1, 1'b1, 7'd6, 32'h1234_5678);
        repeat (3) @(negedge clk);
        drive_ag(2, 1'b0, 1'b0, 7'd0, 32'd0);
        word_rd(0, 7'd6, "R5");
        // R5: monitor read outside its slot keeps its result
        wait_slot(2'd2);
        drive_ag(1, 1'b1, 1'b0, 7'd0, 32'd0);
        repeat (3) @(negedge clk);
        drive_ag(1, 1'b0, 1'b0, 7'd0, 32'd0);
        check("R5", mon_rdata, model[7'h40]);

        // R1: reset mid-run clears words
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) model[i] = 32'd0;
        check("R1", {31'd0, cpu_ready}, 32'd1);
        word_rd(2, 7'h00, "R1");
        word_rd(1, 7'h7F, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule